// File: doc/BRIEF.md
# Multiplex-Mode Display RAM Packer

This block holds the on/off map for a segmented display: one 4-bit word per segment line and one bit per backplane phase. A 1 turns the segment on and a 0 turns it off. A host delivers 8-bit display bytes one at a time. The packer splits each byte into sub-words that match the selected drive mode and writes them into consecutive words, one sub-word per clock cycle. The write pointer moves on by itself and wraps at the end of the memory.

The drive mode sets how many low bits of each word a byte fills. Static mode fills bit 0 only, 1:2 fills bits 0 and 1, 1:3 fills bits 0 to 2, and 1:4 fills all four bits. In 1:3 mode a byte covers only two bits of its third word, so bit 2 of that word keeps its old value.

A read port returns one bit column across every word for a chosen backplane phase. In the lower multiplex modes the unused phases repeat a column that is in use, so paralleled backplane lines carry identical data.

Top module: `segram_packer`

## Requirements
- R1: Synchronous active-high reset clears every stored bit to 0, drops `busy`, and sets the write pointer to word 0, so the first byte after reset starts at word 0.
- R2: A byte is taken on a rising edge where `byte_valid` is 1 and `busy` is 0. From the next cycle `busy` stays high for exactly 8, 4, 3 or 2 cycles (static, 1:2, 1:3, 1:4). `byte_valid` is ignored while `busy` is high, and the memory does not change while `busy` is low.
- R3: With `mode`=00 (static), byte bit 7 down to bit 0 go into bit 0 of eight successive words, MSB first, and bits 1..3 of those words are unchanged.
- R4: With `mode`=01 (1:2), bits 7,6 go into bits 0,1 of the first word, bits 5,4 into the next word, and so on across four words. Bits 2..3 are unchanged.
- R5: With `mode`=10 (1:3), bits 7,6,5 go into bits 0,1,2 of the first word and bits 4,3,2 into the second. Bits 1,0 go into bits 0,1 of the third word, whose bit 2 keeps its previous value. Bit 3 of all three words is unchanged.
- R6: With `mode`=11 (1:4), bits 7..4 go into bits 0..3 of one word and bits 3..0 into bits 0..3 of the next word.
- R7: The pointer advances by one per sub-word and wraps from the last word (NUM_ADDR-1) to word 0. Successive bytes continue where the previous byte stopped.
- R8: While `busy` is 0, a `ptr_load` pulse sets the pointer to `ptr_value`, and a value of NUM_ADDR or more sets it to 0. If `ptr_load` and `byte_valid` arrive in the same cycle, that byte starts at the loaded value. `ptr_load` is ignored while `busy` is 1.
- R9: Bit n of `col_out` is bit c of word n, where c is the column chosen for `rd_phase`. With `mode`=11, c equals `rd_phase`.
- R10: The column choice follows the live `mode`. In static mode every phase reads column 0. In 1:2 mode phases 0,2 read column 0 and phases 1,3 read column 1. In 1:3 mode phase 3 reads column 1 and the other phases read their own column.
- R11: The drive mode is captured when a byte is taken. A change on `mode` during `busy` affects neither the packing nor the length of that byte's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Display byte offered this cycle |
| byte_data | input | 8 | Display byte, consumed MSB first |
| mode | input | 2 | Drive mode: 00 static, 01 1:2, 10 1:3, 11 1:4 |
| ptr_load | input | 1 | Load the write pointer (idle only) |
| ptr_value | input | $clog2(NUM_ADDR) | New pointer value |
| busy | output | 1 | Sub-words of the current byte are still being written |
| rd_phase | input | 2 | Backplane phase to read |
| col_out | output | NUM_ADDR | One bit column, bit n from word n |

## Verification
The bench builds the block with its defaults: 40 words and backplane mirroring enabled. The pointer field is then 6 bits wide, so one load value (45) lies past the end of the memory and exercises the fold to word 0. Loads at words 36 and 38 force both static and 1:4 bytes across the wrap from word 39. The bench also overwrites words that a wider mode filled earlier, which shows which bits a narrower mode must leave untouched, including the top bit of the third word in 1:3 mode.

// File: rtl/segram_pkg.sv
package segram_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 4;

   typedef enum logic [1:0] {
      DRV_STATIC = 2'b00,
      DRV_MUX2   = 2'b01,
      DRV_MUX3   = 2'b10,
      DRV_MUX4   = 2'b11
   } drive_mode_e;

   // bits of each word that one sub-word fills
   function automatic logic [2:0] lanes_of(input drive_mode_e m);
      return {1'b0, m} + 3'd1;
   endfunction

   // sub-words needed to place one byte
   function automatic logic [3:0] steps_of(input drive_mode_e m);
      case (m)
         DRV_STATIC: return 4'd8;
         DRV_MUX2:   return 4'd4;
         DRV_MUX3:   return 4'd3;
         default:    return 4'd2;
      endcase
   endfunction

   // write enables per bit; the final 1:3 sub-word holds only two bits
   function automatic logic [WORD_W-1:0] lane_mask(input drive_mode_e m, input logic last);
      case (m)
         DRV_STATIC: return 4'b0001;
         DRV_MUX2:   return 4'b0011;
         DRV_MUX3:   return last ? 4'b0011 : 4'b0111;
         default:    return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/segram_seq.sv
module segram_seq
   import segram_pkg::*;
#(
   parameter int NUM_ADDR = 40,
   parameter int AW       = $clog2(NUM_ADDR)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  drive_mode_e       mode,
   input  logic              ptr_load,
   input  logic [AW-1:0]     ptr_value,
   output logic              busy,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] wmask,
   output drive_mode_e       wmode
);

   if (WORD_W != 4) begin : g_bad_word
      $error("segram_seq: lane masks assume 4-bit words");
   end

   localparam logic [AW:0]   LIMIT = (AW+1)'(NUM_ADDR);
   localparam logic [AW-1:0] LAST  = AW'(NUM_ADDR - 1);

   logic [BYTE_W-1:0] shreg_q;
   drive_mode_e       mode_q;
   logic [3:0]        left_q;
   logic              busy_q;
   logic [AW-1:0]     ptr_q;
   logic [AW-1:0]     load_ptr;
   logic [AW-1:0]     next_ptr;
   logic              last_sub;

   assign load_ptr = ({1'b0, ptr_value} < LIMIT) ? ptr_value : '0;
   assign next_ptr = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   assign last_sub = (left_q == 4'd1);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         ptr_q   <= '0;
         shreg_q <= '0;
         mode_q  <= DRV_STATIC;
         left_q  <= '0;
      end else if (!busy_q) begin
         if (byte_valid) begin
            shreg_q <= byte_data;
            mode_q  <= mode;
            left_q  <= steps_of(mode);
            busy_q  <= 1'b1;
         end
         if (ptr_load) begin
            ptr_q <= load_ptr;
         end
      end else begin
         shreg_q <= shreg_q << lanes_of(mode_q);
         ptr_q   <= next_ptr;
         left_q  <= left_q - 4'd1;
         if (last_sub) begin
            busy_q <= 1'b0;
         end
      end
   end

   // the MSB-first head of the shifter lands in bit 0 upward
   for (genvar j = 0; j < WORD_W; j++) begin : g_lane
      assign wdata[j] = shreg_q[BYTE_W-1-j];
   end

   assign we    = busy_q;
   assign waddr = ptr_q;
   assign wmask = lane_mask(mode_q, last_sub);
   assign busy  = busy_q;
   assign wmode = mode_q;

endmodule

// File: rtl/segram_store.sv
module segram_store
   import segram_pkg::*;
#(
   parameter int NUM_ADDR = 40,
   parameter int AW       = $clog2(NUM_ADDR)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [AW-1:0]                    waddr,
   input  logic [WORD_W-1:0]                wdata,
   input  logic [WORD_W-1:0]                wmask,
   output logic [WORD_W-1:0][NUM_ADDR-1:0]  cols
);

   logic [WORD_W-1:0] mem_q [NUM_ADDR];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int a = 0; a < NUM_ADDR; a++) begin
            mem_q[a] <= '0;
         end
      end else if (we) begin
         mem_q[waddr] <= (mem_q[waddr] & ~wmask) | (wdata & wmask);
      end
   end

   always_comb begin
      for (int a = 0; a < NUM_ADDR; a++) begin
         for (int b = 0; b < WORD_W; b++) begin
            cols[b][a] = mem_q[a][b];
         end
      end
   end

endmodule

// File: rtl/segram_colsel.sv
module segram_colsel
   import segram_pkg::*;
#(
   parameter int NUM_ADDR  = 40,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic [WORD_W-1:0][NUM_ADDR-1:0] cols,
   input  drive_mode_e                     mode,
   input  logic [1:0]                      phase,
   output logic [NUM_ADDR-1:0]             col_out
);

   logic [1:0] src;

   if (MIRROR_EN) begin : g_mirror
      always_comb begin
         case (mode)
            DRV_STATIC: src = 2'd0;
            DRV_MUX2:   src = {1'b0, phase[0]};
            DRV_MUX3:   src = (phase == 2'd3) ? 2'd1 : phase;
            default:    src = phase;
         endcase
      end
   end else begin : g_direct
      assign src = phase;
   end

   assign col_out = cols[src];

endmodule

// File: rtl/segram_packer.sv
module segram_packer
   import segram_pkg::*;
#(
   parameter int NUM_ADDR  = 40,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        byte_valid,
   input  logic [7:0]                  byte_data,
   input  logic [1:0]                  mode,
   input  logic                        ptr_load,
   input  logic [$clog2(NUM_ADDR)-1:0] ptr_value,
   output logic                        busy,
   input  logic [1:0]                  rd_phase,
   output logic [NUM_ADDR-1:0]         col_out
);

   localparam int AW = $clog2(NUM_ADDR);

   if (NUM_ADDR < 2 || NUM_ADDR > 256) begin : g_bad_depth
      $error("segram_packer: NUM_ADDR must lie in 2..256");
   end

   drive_mode_e                     mode_e;
   drive_mode_e                     wmode;
   logic                            we;
   logic [AW-1:0]                   wptr;
   logic [WORD_W-1:0]               wdata;
   logic [WORD_W-1:0]               wmask;
   logic [WORD_W-1:0][NUM_ADDR-1:0] cols;

   assign mode_e = drive_mode_e'(mode);

   segram_seq #(.NUM_ADDR(NUM_ADDR), .AW(AW)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .mode       (mode_e),
      .ptr_load   (ptr_load),
      .ptr_value  (ptr_value),
      .busy       (busy),
      .we         (we),
      .waddr      (wptr),
      .wdata      (wdata),
      .wmask      (wmask),
      .wmode      (wmode)
   );

   segram_store #(.NUM_ADDR(NUM_ADDR), .AW(AW)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .waddr (wptr),
      .wdata (wdata),
      .wmask (wmask),
      .cols  (cols)
   );

   segram_colsel #(.NUM_ADDR(NUM_ADDR), .MIRROR_EN(MIRROR_EN)) u_colsel (
      .cols    (cols),
      .mode    (mode_e),
      .phase   (rd_phase),
      .col_out (col_out)
   );

endmodule

// File: rtl/segram_checker.sv
module segram_checker
   import segram_pkg::*;
#(
   parameter int NUM_ADDR = 40,
   parameter int AW       = $clog2(NUM_ADDR)
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            byte_valid,
   input logic                            busy,
   input logic [AW-1:0]                   wptr,
   input drive_mode_e                     wmode,
   input logic [WORD_W-1:0][NUM_ADDR-1:0] cols
);

   logic [3:0] busy_run;

   always_ff @(posedge clk) begin
      if (rst)       busy_run <= '0;
      else if (busy) busy_run <= busy_run + 4'd1;
      else           busy_run <= '0;
   end

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
      (!busy && byte_valid) |=> busy); // R2

   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      busy_run <= 4'd8); // R2

   AST_IDLE_HOLDS_RAM: assert property (@(posedge clk) disable iff (rst)
      !busy |=> $stable(cols)); // R2

   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      {1'b0, wptr} < (AW+1)'(NUM_ADDR)); // R7

   AST_PTR_STEPS: assert property (@(posedge clk) disable iff (rst)
      busy |=> (wptr == (($past(wptr) == AW'(NUM_ADDR-1)) ? '0 : $past(wptr) + 1'b1))); // R7

   AST_STATIC_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
      (busy && wmode == DRV_STATIC) |=> $stable(cols[3:1])); // R3

   AST_MUX3_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
      (busy && wmode == DRV_MUX3) |=> $stable(cols[3])); // R5

endmodule

bind segram_packer segram_checker #(.NUM_ADDR(NUM_ADDR)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .byte_valid (byte_valid),
   .busy       (busy),
   .wptr       (wptr),
   .wmode      (wmode),
   .cols       (cols)
);

// File: tb/segram_packer_test.sv
`timescale 1ns/1ps
module segram_packer_test;

   localparam int N  = 40;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = '0;
   logic [1:0]    mode = 2'b00;
   logic          ptr_load = 1'b0;
   logic [AW-1:0] ptr_value = '0;
   logic [1:0]    rd_phase = 2'd0;
   logic          busy;
   logic [N-1:0]  col_out;

   int checks = 0;
   int errors = 0;
   logic [3:0] model [N];
   int mptr = 0;

   always #2.5 clk = ~clk;

   segram_packer #(.NUM_ADDR(N), .MIRROR_EN(1'b1)) uut (
      .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
      .mode(mode), .ptr_load(ptr_load), .ptr_value(ptr_value), .busy(busy),
      .rd_phase(rd_phase), .col_out(col_out)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int steps(input logic [1:0] m);
      case (m)
         2'b00: return 8;
         2'b01: return 4;
         2'b10: return 3;
         default: return 2;
      endcase
   endfunction

   task automatic model_write(input logic [7:0] d, input logic [1:0] m);
      int bpw = int'(m) + 1;
      for (int s = 0; s < steps(m); s++) begin
         for (int j = 0; j < bpw; j++) begin
            int idx = s * bpw + j;
            if (idx < 8) model[mptr][j] = d[7-idx];
         end
         mptr = (mptr == N-1) ? 0 : mptr + 1;
      end
   endtask

   function automatic logic [N-1:0] model_col(input int c);
      logic [N-1:0] v;
      for (int a = 0; a < N; a++) v[a] = model[a][c];
      return v;
   endfunction

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 20) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic send_byte(input logic [7:0] d, input logic [1:0] m, input string req);
      int n;
      @(negedge clk);
      byte_valid = 1'b1; byte_data = d; mode = m;
      @(negedge clk);
      byte_valid = 1'b0;
      wait_idle(n);
      chk(req, "busy cycles", n, steps(m));
      model_write(d, m);
   endtask

   task automatic load_ptr(input int v);
      @(negedge clk);
      ptr_load = 1'b1; ptr_value = AW'(v);
      @(negedge clk);
      ptr_load = 1'b0;
      mptr = (v < N) ? v : 0;
   endtask

   task automatic read_all(input string req);
      @(negedge clk);
      mode = 2'b11;
      for (int k = 0; k < 4; k++) begin
         rd_phase = 2'(k);
         #1;
         chk(req, $sformatf("column %0d", k), col_out, model_col(k));
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int a = 0; a < N; a++) model[a] = '0;
      mptr = 0;
      chk("R1", "busy after reset", busy, 0);
      read_all("R1");
      send_byte(8'h80, 2'b00, "R1");
      read_all("R1");
   endtask

   task automatic t_static();
      load_ptr(10);
      send_byte(8'hFF, 2'b11, "R6");
      load_ptr(10);
      send_byte(8'h00, 2'b00, "R3");
      read_all("R3");
      send_byte(8'hA5, 2'b00, "R3");
      read_all("R3");
   endtask

   task automatic t_mux2();
      load_ptr(20);
      send_byte(8'hFF, 2'b11, "R6");
      load_ptr(20);
      send_byte(8'h96, 2'b01, "R4");
      read_all("R4");
   endtask

   task automatic t_mux3();
      load_ptr(24);
      send_byte(8'hFF, 2'b11, "R6");
      send_byte(8'hFF, 2'b11, "R6");
      load_ptr(24);
      send_byte(8'h00, 2'b10, "R5");
      read_all("R5");
      send_byte(8'h6B, 2'b10, "R5");
      read_all("R5");
   endtask

   task automatic t_mux4();
      load_ptr(30);
      send_byte(8'hC3, 2'b11, "R6");
      send_byte(8'h1E, 2'b11, "R6");
      read_all("R6");
      read_all("R9");
   endtask

   task automatic t_wrap();
      load_ptr(38);
      send_byte(8'h5A, 2'b11, "R7");
      send_byte(8'hA5, 2'b11, "R7");
      read_all("R7");
      load_ptr(36);
      send_byte(8'hFF, 2'b00, "R7");
      read_all("R7");
   endtask

   task automatic t_load();
      int n;
      load_ptr(45);
      send_byte(8'hF0, 2'b01, "R8");
      read_all("R8");
      // load and byte together: byte starts at the loaded word
      @(negedge clk);
      ptr_load = 1'b1; ptr_value = AW'(12); byte_valid = 1'b1; byte_data = 8'h3C; mode = 2'b11;
      @(negedge clk);
      ptr_load = 1'b0; byte_valid = 1'b0;
      wait_idle(n);
      chk("R8", "busy cycles", n, 2);
      mptr = 12;
      model_write(8'h3C, 2'b11);
      read_all("R8");
      // load and byte offered while busy are both dropped
      load_ptr(2);
      @(negedge clk);
      byte_valid = 1'b1; byte_data = 8'h00; mode = 2'b00;
      @(negedge clk);
      ptr_load = 1'b1; ptr_value = AW'(33); byte_data = 8'hFF;
      @(negedge clk);
      ptr_load = 1'b0; byte_valid = 1'b0;
      wait_idle(n);
      chk("R2", "busy cycles with extra offer", n, 7);
      model_write(8'h00, 2'b00);
      read_all("R2");
      send_byte(8'hFF, 2'b00, "R8");
      read_all("R8");
   endtask

   task automatic t_mirror();
      int c;
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode = 2'(m); rd_phase = 2'(k);
            #1;
            case (m)
               0: c = 0;
               1: c = k % 2;
               2: c = (k == 3) ? 1 : k;
               default: c = k;
            endcase
            chk("R10", $sformatf("mode %0d phase %0d", m, k), col_out, model_col(c));
         end
      end
   endtask

   task automatic t_mode_hold();
      int n;
      load_ptr(5);
      @(negedge clk);
      byte_valid = 1'b1; byte_data = 8'hE4; mode = 2'b01;
      @(negedge clk);
      byte_valid = 1'b0; mode = 2'b00;
      wait_idle(n);
      chk("R11", "busy cycles", n, 4);
      model_write(8'hE4, 2'b01);
      read_all("R11");
   endtask

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_static();
      t_mux2();
      t_mux3();
      t_mux4();
      t_wrap();
      t_load();
      t_mirror();
      t_mode_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule